// File: doc/BRIEF.md
# Free-Running Sync Counter Register Block

This peripheral keeps a 32-bit up-counter that advances once for every pulse on a tick-enable input. The tick input is driven at 32768 pulses per second, so the count is slow time elapsed since reset. Software reads the count through a small synchronous slave port. The port also exposes a fixed revision code. Every access is answered one clock after its strobe, with registered read data and a one-cycle error flag.

A 32-bit master reads the count in one word access. A 16-bit master reads the lower half first. That read also copies the upper half of the same value into a holding register. A later upper-half read returns that copy, so the two halves always belong to the same sample, even if the counter has moved on in between. The block has no writable state. Writes, illegal widths and unknown offsets only raise the error flag.

Top module: `sync_count_regs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the counter and the holding register are zero and `rdData` and `rdErr` are zero.
- R2: The counter increases by exactly one at every clock edge where `tickEn` is high, and holds its value otherwise.
- R3: A word read (`busSize`=2) at address 0x00 returns 0x00000021 with `rdErr` low.
- R4: A word read at address 0x10 returns the counter value present at the clock edge of the read strobe. The value is on `rdData` one cycle after the strobe.
- R5: A half-word read (`busSize`=1) at 0x00 or 0x10 returns bits 15:0 of that register, zero-extended. It also stores bits 31:16 of the same value in the holding register.
- R6: A half-word read at 0x02 or 0x12 returns the holding register, zero-extended, and never the live counter. The holding register changes only on the reads named in R5.
- R7: A read with `busSize` 0 (byte) or 3 (reserved) raises `rdErr`, returns zero and changes no state.
- R8: A write at any address, including one issued together with a read, raises `rdErr`, returns zero and leaves the counter and the holding register unchanged.
- R9: A read at any other offset raises `rdErr` and returns zero. This covers a word read that is not at 0x00 or 0x10, and a half-word read that is not at 0x00, 0x02, 0x10 or 0x12, odd addresses included.
- R10: `rdErr` is high for exactly the one cycle that follows an erroneous strobe. In a cycle that follows no strobe, `rdData` and `rdErr` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-enable pulse at the slow tick rate |
| busAddr | input | ADDR_W (8) | Byte address of the access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busSize | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| rdData | output | 32 | Registered read data, valid one cycle after the strobe |
| rdErr | output | 1 | One-cycle error pulse aligned with `rdData` |

## Verification
The hardest case to reach is an upper-half read that returns a value different from the live counter's upper half. This needs the counter to cross a 65536 boundary between the lower-half read and the upper-half read. The bench holds `tickEn` high for long runs, so the count passes 0x10000 before the lower-half read. It then runs the count past 0x20000 before reading the upper half, and expects the stale value 1. Word reads and rejected accesses placed between the two half reads show that nothing else disturbs the holding register.

// File: rtl/sync_count_pkg.sv
package sync_count_pkg;

  // Source picked by the decoder for the next read-data word
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_REV  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_HOLD = 2'd3
  } srcSel_e;

  // Encoding of the busSize input
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // Strobes from decode control to the datapath
  typedef struct packed {
    srcSel_e src;
    logic    lowHalf;
    logic    capture;
    logic    err;
  } dpStrobe_t;

  localparam int          DATA_W   = 32;
  localparam logic [31:0] REV_CODE = 32'h0000_0021;

endpackage

// File: rtl/sync_count_ctrl.sv
module sync_count_ctrl
  import sync_count_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REV_OFS = 'h00,
  parameter int CNT_OFS = 'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  output dpStrobe_t         strb
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] REV_IDX = IDX_W'(REV_OFS >> 2);
  localparam logic [IDX_W-1:0] CNT_IDX = IDX_W'(CNT_OFS >> 2);

  logic [IDX_W-1:0] wordIdx;
  logic             hitRev;
  logic             hitCnt;
  accSize_e         accSize;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign hitRev  = (wordIdx == REV_IDX);
  assign hitCnt  = (wordIdx == CNT_IDX);
  assign accSize = accSize_e'(busSize);

  always_comb begin
    strb = '{src: SRC_ZERO, lowHalf: 1'b0, capture: 1'b0, err: 1'b0};
    if (busWr) begin
      strb.err = 1'b1;
    end else if (busRd) begin
      unique case (accSize)
        SZ_WORD: begin
          if (busAddr[1:0] != 2'b00) strb.err = 1'b1;
          else if (hitRev)           strb.src = SRC_REV;
          else if (hitCnt)           strb.src = SRC_CNT;
          else                       strb.err = 1'b1;
        end
        SZ_HALF: begin
          if (busAddr[0] || !(hitRev || hitCnt)) begin
            strb.err = 1'b1;
          end else if (busAddr[1]) begin
            strb.src = SRC_HOLD;
          end else begin
            strb.src     = hitRev ? SRC_REV : SRC_CNT;
            strb.lowHalf = 1'b1;
            strb.capture = 1'b1;
          end
        end
        default: strb.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/sync_count_dp.sv
module sync_count_dp
  import sync_count_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  dpStrobe_t         strb,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] cntReg;
  logic [HALF_W-1:0] holdReg;
  logic [DATA_W-1:0] srcVal;

  always_comb begin
    unique case (strb.src)
      SRC_REV:  srcVal = REV_CODE;
      SRC_CNT:  srcVal = cntReg;
      SRC_HOLD: srcVal = {{HALF_W{1'b0}}, holdReg};
      default:  srcVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg  <= '0;
      holdReg <= '0;
      rdData  <= '0;
      rdErr   <= 1'b0;
    end else begin
      if (tickEn)       cntReg  <= cntReg + 1'b1;
      if (strb.capture) holdReg <= srcVal[DATA_W-1:HALF_W];
      rdErr  <= strb.err;
      rdData <= strb.lowHalf ? {{HALF_W{1'b0}}, srcVal[HALF_W-1:0]} : srcVal;
    end
  end

  // R2: counter steps by one per tick and is otherwise frozen
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> cntReg == $past(cntReg) + 1'b1);
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cntReg));
  // R6: holding register only moves on a low-half capture
  assert_hold_only_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(holdReg));
  // R8: an error cycle carries zero data
  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdData == '0);

endmodule

// File: rtl/sync_count_regs.sv
module sync_count_regs
  import sync_count_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);

  dpStrobe_t strb;

  sync_count_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busSize (busSize),
    .strb    (strb)
  );

  sync_count_dp dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .strb   (strb),
    .rdData (rdData),
    .rdErr  (rdErr)
  );

  // R10: no strobe, quiet outputs next cycle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |=> (rdData == '0 && !rdErr));
  // R8: every write is flagged
  assert_write_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> rdErr);
  // R3: revision word read
  assert_rev_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busSize == 2'd2 && busAddr == '0) |=> (rdData == REV_CODE && !rdErr));
  // R7: byte and reserved widths are flagged
  assert_bad_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busSize == 2'd0 || busSize == 2'd3)) |=> rdErr);

endmodule

// File: tb/sync_count_regs_tb_top.sv
module sync_count_regs_tb_top;

  typedef struct packed {
    logic [7:0] ticks;
    logic       wr;
    logic [1:0] sz;
    logic [7:0] addr;
    logic       expErr;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'd3, 1'b0, 2'd2, 8'h10, 1'b0, 4'd4},  // R4 word count read
    '{8'd0, 1'b0, 2'd2, 8'h00, 1'b0, 4'd3},  // R3 revision word
    '{8'd5, 1'b0, 2'd1, 8'h10, 1'b0, 4'd5},  // R5 low half of count
    '{8'd0, 1'b0, 2'd1, 8'h12, 1'b0, 4'd6},  // R6 upper half from hold
    '{8'd0, 1'b0, 2'd1, 8'h00, 1'b0, 4'd5},  // R5 low half of revision
    '{8'd2, 1'b0, 2'd0, 8'h10, 1'b1, 4'd7},  // R7 byte read
    '{8'd0, 1'b0, 2'd3, 8'h10, 1'b1, 4'd7},  // R7 reserved width
    '{8'd0, 1'b1, 2'd2, 8'h10, 1'b1, 4'd8},  // R8 write
    '{8'd0, 1'b0, 2'd2, 8'h04, 1'b1, 4'd9},  // R9 unknown word offset
    '{8'd0, 1'b0, 2'd1, 8'h08, 1'b1, 4'd9},  // R9 unknown half offset
    '{8'd0, 1'b0, 2'd2, 8'h12, 1'b1, 4'd9},  // R9 word at upper alias
    '{8'd1, 1'b0, 2'd1, 8'h02, 1'b0, 4'd6},  // R6 hold via 0x02 alias
    '{8'd0, 1'b0, 2'd1, 8'h11, 1'b1, 4'd9}   // R9 odd half address
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] rdData;
  logic        rdErr;

  int          errors = 0;
  int          checks = 0;
  logic        done = 1'b0;
  logic [31:0] mCnt = '0;
  logic [15:0] mHold = '0;

  always #2 clk = ~clk;

  sync_count_regs #(.ADDR_W(8)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busSize (busSize),
    .rdData  (rdData),
    .rdErr   (rdErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
      mCnt = mCnt + 32'(n);
    end
  endtask

  task automatic doAccess(input logic wr, input logic [1:0] sz, input logic [7:0] ad,
                          output logic [31:0] d, output logic e);
    @(negedge clk);
    busWr = wr; busRd = ~wr; busSize = sz; busAddr = ad;
    @(negedge clk);
    d = rdData; e = rdErr;
    busWr = 1'b0; busRd = 1'b0;
  endtask

  // Reference behaviour from the requirements; updates mHold
  function automatic logic [31:0] model(input logic wr, input logic [1:0] sz,
                                        input logic [7:0] ad, output logic e);
    logic [7:0]  base;
    logic [31:0] v;
    e = 1'b0;
    model = '0;
    base = ad & 8'hFC;
    if (wr) e = 1'b1;
    else if (sz == 2'd2) begin
      if (ad == 8'h00) model = 32'h21;
      else if (ad == 8'h10) model = mCnt;
      else e = 1'b1;
    end else if (sz == 2'd1) begin
      if (ad[0] || (base != 8'h00 && base != 8'h10)) e = 1'b1;
      else if (ad[1]) model = {16'h0, mHold};
      else begin
        v = (base == 8'h00) ? 32'h21 : mCnt;
        model = {16'h0, v[15:0]};
        mHold = v[31:16];
      end
    end else e = 1'b1;
  endfunction

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic        e;
    logic [31:0] expD;
    logic        expE;
    repeat (3) @(negedge clk);
    check("R1 rdData in reset", rdData, 32'h0);
    check("R1 rdErr in reset", {31'h0, rdErr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", rdData, 32'h0);
    doAccess(1'b0, 2'd2, 8'h10, d, e);
    check("R1 counter zero", d, 32'h0);
    doAccess(1'b0, 2'd1, 8'h12, d, e);
    check("R1 hold zero", d, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      runTicks(int'(VECS[i].ticks));
      expD = model(VECS[i].wr, VECS[i].sz, VECS[i].addr, expE);
      doAccess(VECS[i].wr, VECS[i].sz, VECS[i].addr, d, e);
      check($sformatf("R%0d table[%0d] data", VECS[i].req, i), d, expD);
      check($sformatf("R%0d table[%0d] err", VECS[i].req, i), {31'h0, e}, {31'h0, VECS[i].expErr});
    end

    // R10: error pulse lasts one cycle, idle cycle is quiet
    doAccess(1'b0, 2'd0, 8'h00, d, e);
    check("R10 err pulse", {31'h0, e}, 32'h1);
    @(negedge clk);
    check("R10 err dropped", {31'h0, rdErr}, 32'h0);
    check("R10 idle data", rdData, 32'h0);

    // R2: long tick run, count passes 0x10000
    runTicks(70000 - int'(mCnt));
    doAccess(1'b0, 2'd2, 8'h10, d, e);
    check("R2 R4 count after long run", d, 32'd70000);
    // R5: low half captures upper = 1
    doAccess(1'b0, 2'd1, 8'h10, d, e);
    check("R5 low half", d, {16'h0, mCnt[15:0]});
    runTicks(62000);
    // R6: disturbing accesses between halves
    doAccess(1'b0, 2'd2, 8'h10, d, e);
    check("R4 count past 0x20000", d, 32'd132000);
    doAccess(1'b1, 2'd1, 8'h10, d, e);
    check("R8 write flagged", {31'h0, e}, 32'h1);
    doAccess(1'b0, 2'd0, 8'h10, d, e);
    check("R7 byte data zero", d, 32'h0);
    doAccess(1'b0, 2'd1, 8'h12, d, e);
    check("R6 stale upper half", d, 32'h1);
    // R8: write with simultaneous read still only flags
    @(negedge clk);
    busWr = 1'b1; busRd = 1'b1; busSize = 2'd2; busAddr = 8'h10;
    @(negedge clk);
    check("R8 write+read data", rdData, 32'h0);
    check("R8 write+read err", {31'h0, rdErr}, 32'h1);
    busWr = 1'b0; busRd = 1'b0;
    doAccess(1'b0, 2'd2, 8'h10, d, e);
    check("R8 counter untouched", d, 32'd132000);

    // R1: reset mid-run clears counter and hold
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doAccess(1'b0, 2'd1, 8'h12, d, e);
    check("R1 hold cleared", d, 32'h0);
    doAccess(1'b0, 2'd2, 8'h10, d, e);
    check("R1 counter cleared", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule